// File: doc/BRIEF.md
# L2 Cache SRAM Strobe Sequencer

This block generates the active-low control strobes for an external pipelined-burst SRAM array that serves as a second-level cache. A host bridge reports the kind of cycle it is running: a read hit, write hit, line fill, writeback, PCI-initiated DRAM hit, CPU-to-PCI memory read, non-cacheable read or read miss without writeback. It gives this as a 3-bit code with a one-clock start pulse. The block then plays out a fixed four-beat window. In each beat it drives the SRAM address strobe, burst advance, chip enable, output enable and per-lane byte write enables as the cycle type requires. One clock after the last beat it raises a done pulse.

The cycle code, the byte enables and the bus-ownership flag are captured on the clock that accepts the start. Later changes to those inputs have no effect until the next accepted start. The start input is a plain request with no ready handshake. The block applies no back-pressure: a start that arrives while a window is running is dropped, and the bridge must wait for done before it requests the next window. A start in the same clock that done is high is accepted, so windows can run back to back. Every strobe comes straight from a flop and changes only on the rising clock edge.

Top module: `l2ctl_sram_seq`

## Requirements
- R1: After reset, and whenever no window is running, every strobe (address, advance, chip enable, output enable, all eight byte write enables) is high and done_o is low.
- R2: A start sampled high while idle opens a window. The first beat's strobes appear in the clock after that edge, and the window lasts four beats. done_o is high for exactly one clock, the clock after the fourth beat, and in that clock all strobes are high.
- R3: cads_n goes low only in the first beat of a PCI-to-DRAM hit (code 4), and only when bus_owned_i was high at start. It stays high for every other code.
- R4: cadv_n is low in beats two to four of read hit (0), write hit (1), line fill (2) and writeback (3). It stays high in beat one and for codes 4 to 7.
- R5: ce_n is low in all four beats for codes 0 to 4, and in only the first two beats for codes 5 to 7.
- R6: coe_n is low in all four beats for read hit (0), writeback (3) and PCI hit (4).
- R7: coe_n is low in only the first two beats for CPU-to-PCI read (5), non-cacheable read (6) and read miss without writeback (7). It stays high throughout for write hit (1) and line fill (2).
- R8: For a write hit (1), bwe_n[i] is low in every beat exactly when be_i[i] was high at start, where bit i is byte lane i. For a line fill (2), all eight lanes are low. For every other code, all lanes stay high.
- R9: coe_n and any bwe_n bit are never low in the same clock.
- R10: A start sampled while a window is running is ignored. The running window keeps its code and timing, and no extra window or done pulse follows.
- R11: A start sampled in the clock in which done_o is high is accepted, and its first beat follows in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to open a window |
| ctype_i | input | 3 | Cycle code 0..7 as listed in R3 to R8 |
| be_i | input | 8 | Byte-lane enables, active high, bit i = lane i |
| bus_owned_i | input | 1 | High when the host bus has been taken from the processor |
| cads_n | output | 1 | SRAM address strobe, active low |
| cadv_n | output | 1 | SRAM burst advance, active low |
| ce_n | output | 1 | SRAM chip enable, active low |
| coe_n | output | 1 | SRAM output enable, active low |
| bwe_n | output | 8 | Per-lane byte write enable, active low |
| done_o | output | 1 | One-clock pulse after the last beat |

## Verification
The bench targets where output-enable timing splits: at beat two on codes 5 to 7, against a full window on hits and writebacks. A design that mixed up the two profiles would leave the SRAM driving the bus too long or too briefly. It sends a PCI hit with the bus not owned, a write hit with zero and with all byte enables, and a fill with sparse enables. An address strobe driven without bus ownership, or writes that ignore the lane mask, both show up here. It pulses start in the middle of a window, where a faulty design would restart or switch cycle type. It also starts a window in the done clock, where an off-by-one in the idle test would drop the request.

// File: rtl/l2ctl_pkg.sv
package l2ctl_pkg;

  typedef enum logic [2:0] {
    CYC_RD_HIT   = 3'd0,
    CYC_WR_HIT   = 3'd1,
    CYC_FILL     = 3'd2,
    CYC_WBACK    = 3'd3,
    CYC_PCI_HIT  = 3'd4,
    CYC_CPU_PCI  = 3'd5,
    CYC_NC_RD    = 3'd6,
    CYC_MISS_RD  = 3'd7
  } cyc_e;

  // Per-cycle-type strobe profile
  typedef struct packed {
    logic oe_full;   // output enable for the whole window
    logic oe_short;  // output enable for the early beats only
    logic adv;       // burst advance after the first beat
    logic wr_mask;   // write lanes selected by byte enables
    logic wr_all;    // write every lane
    logic pci_cads;  // address strobe on first beat when bus owned
    logic ce_full;   // chip enable for the whole window
  } prof_t;

endpackage

// File: rtl/l2ctl_profile.sv
module l2ctl_profile
  import l2ctl_pkg::*;
(
  input  cyc_e  ctype,
  output prof_t prof
);
  always_comb begin
    prof = '0;
    unique case (ctype)
      CYC_RD_HIT:  begin prof.oe_full = 1'b1; prof.adv = 1'b1; prof.ce_full = 1'b1; end
      CYC_WR_HIT:  begin prof.wr_mask = 1'b1; prof.adv = 1'b1; prof.ce_full = 1'b1; end
      CYC_FILL:    begin prof.wr_all  = 1'b1; prof.adv = 1'b1; prof.ce_full = 1'b1; end
      CYC_WBACK:   begin prof.oe_full = 1'b1; prof.adv = 1'b1; prof.ce_full = 1'b1; end
      CYC_PCI_HIT: begin prof.oe_full = 1'b1; prof.pci_cads = 1'b1; prof.ce_full = 1'b1; end
      CYC_CPU_PCI, CYC_NC_RD, CYC_MISS_RD: prof.oe_short = 1'b1;
      default:     prof = '0;
    endcase
  end
endmodule

// File: rtl/l2ctl_beat_fsm.sv
module l2ctl_beat_fsm
  import l2ctl_pkg::*;
#(
  parameter int LINE_BEATS = 4,
  parameter int BE_W       = 8,
  localparam int BEAT_W    = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  cyc_e              ctype_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              own_i,
  // next-state view, consumed by the strobe register stage
  output logic              busy_d,
  output logic [BEAT_W-1:0] beat_d,
  output cyc_e              ctype_d,
  output logic [BE_W-1:0]   be_d,
  output logic              own_d,
  // registered state
  output logic              busy_q,
  output logic [BEAT_W-1:0] beat_q,
  output cyc_e              ctype_q,
  output logic              own_q,
  output logic              done_q
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(LINE_BEATS - 1);

  logic [BE_W-1:0] be_q;
  logic            accept;
  logic            at_last;

  assign accept  = !busy_q && start_i;
  assign at_last = busy_q && (beat_q == LAST);

  always_comb begin
    busy_d  = busy_q;
    beat_d  = beat_q;
    ctype_d = ctype_q;
    be_d    = be_q;
    own_d   = own_q;
    if (accept) begin
      busy_d  = 1'b1;
      beat_d  = '0;
      ctype_d = ctype_i;
      be_d    = be_i;
      own_d   = own_i;
    end else if (at_last) begin
      busy_d = 1'b0;
      beat_d = '0;
    end else if (busy_q) begin
      beat_d = beat_q + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
      ctype_q <= CYC_RD_HIT;
      be_q    <= '0;
      own_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      beat_q  <= beat_d;
      ctype_q <= ctype_d;
      be_q    <= be_d;
      own_q   <= own_d;
      done_q  <= at_last;
    end
  end
endmodule

// File: rtl/l2ctl_strobe_gen.sv
module l2ctl_strobe_gen
  import l2ctl_pkg::*;
#(
  parameter int LINE_BEATS     = 4,
  parameter int SHORT_OE_BEATS = 2,
  parameter int BE_W           = 8,
  localparam int BEAT_W        = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_d,
  input  logic [BEAT_W-1:0] beat_d,
  input  prof_t             prof_d,
  input  logic [BE_W-1:0]   be_d,
  input  logic              own_d,
  output logic              cads_n,
  output logic              cadv_n,
  output logic              ce_n,
  output logic              coe_n,
  output logic [BE_W-1:0]   bwe_n
);
  localparam logic [BEAT_W-1:0] SHORT = BEAT_W'(SHORT_OE_BEATS);

  logic            early;
  logic            oe_on;
  logic            ce_on;
  logic            cads_on;
  logic            adv_on;
  logic [BE_W-1:0] wr_on;

  assign early   = beat_d < SHORT;
  assign oe_on   = busy_d && (prof_d.oe_full || (prof_d.oe_short && early));
  assign ce_on   = busy_d && (prof_d.ce_full || early);
  assign cads_on = busy_d && prof_d.pci_cads && own_d && (beat_d == '0);
  assign adv_on  = busy_d && prof_d.adv && (beat_d != '0);

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign wr_on[i] = busy_d && !oe_on && (prof_d.wr_all || (prof_d.wr_mask && be_d[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cads_n <= 1'b1;
      cadv_n <= 1'b1;
      ce_n   <= 1'b1;
      coe_n  <= 1'b1;
      bwe_n  <= '1;
    end else begin
      cads_n <= !cads_on;
      cadv_n <= !adv_on;
      ce_n   <= !ce_on;
      coe_n  <= !oe_on;
      bwe_n  <= ~wr_on;
    end
  end
endmodule

// File: rtl/l2ctl_sram_seq.sv
module l2ctl_sram_seq
  import l2ctl_pkg::*;
#(
  parameter int LINE_BEATS     = 4,
  parameter int SHORT_OE_BEATS = 2,
  parameter int BE_W           = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2:0]      ctype_i,
  input  logic [BE_W-1:0] be_i,
  input  logic            bus_owned_i,
  output logic            cads_n,
  output logic            cadv_n,
  output logic            ce_n,
  output logic            coe_n,
  output logic [BE_W-1:0] bwe_n,
  output logic            done_o
);
  localparam int BEAT_W = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;

  logic              busy_d, busy_q, own_d, own_q;
  logic [BEAT_W-1:0] beat_d, beat_q;
  cyc_e              ctype_d, ctype_q;
  logic [BE_W-1:0]   be_d;
  prof_t             prof_d;

  l2ctl_beat_fsm #(.LINE_BEATS(LINE_BEATS), .BE_W(BE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctype_i(cyc_e'(ctype_i)),
    .be_i(be_i), .own_i(bus_owned_i),
    .busy_d(busy_d), .beat_d(beat_d), .ctype_d(ctype_d), .be_d(be_d), .own_d(own_d),
    .busy_q(busy_q), .beat_q(beat_q), .ctype_q(ctype_q), .own_q(own_q), .done_q(done_o)
  );

  l2ctl_profile u_prof (.ctype(ctype_d), .prof(prof_d));

  l2ctl_strobe_gen #(.LINE_BEATS(LINE_BEATS), .SHORT_OE_BEATS(SHORT_OE_BEATS), .BE_W(BE_W)) u_strb (
    .clk(clk), .rst_n(rst_n), .busy_d(busy_d), .beat_d(beat_d), .prof_d(prof_d),
    .be_d(be_d), .own_d(own_d),
    .cads_n(cads_n), .cadv_n(cadv_n), .ce_n(ce_n), .coe_n(coe_n), .bwe_n(bwe_n)
  );
endmodule

// File: rtl/l2ctl_sram_seq_chk.sv
module l2ctl_sram_seq_chk
  import l2ctl_pkg::*;
#(
  parameter int LINE_BEATS = 4,
  parameter int BE_W       = 8,
  parameter int BEAT_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cads_n,
  input logic              cadv_n,
  input logic              ce_n,
  input logic              coe_n,
  input logic [BE_W-1:0]   bwe_n,
  input logic              done_o,
  input logic              busy_q,
  input logic [BEAT_W-1:0] beat_q,
  input cyc_e              ctype_q,
  input logic              own_q
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(LINE_BEATS - 1);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cads_n && cadv_n && ce_n && coe_n && (&bwe_n)));

  p_cads_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cads_n |-> (busy_q && own_q && ctype_q == CYC_PCI_HIT && beat_q == '0));

  p_adv_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cadv_n |-> (busy_q && beat_q != '0));

  p_ce_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!coe_n || !(&bwe_n) || !cadv_n || !cads_n) |-> !ce_n);

  p_oe_bwe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!coe_n && !(&bwe_n)));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && beat_q != LAST) |=> (busy_q && $stable(ctype_q)));
endmodule

bind l2ctl_sram_seq l2ctl_sram_seq_chk #(
  .LINE_BEATS(LINE_BEATS), .BE_W(BE_W), .BEAT_W(BEAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .cads_n(cads_n), .cadv_n(cadv_n), .ce_n(ce_n), .coe_n(coe_n), .bwe_n(bwe_n),
  .done_o(done_o), .busy_q(busy_q), .beat_q(beat_q), .ctype_q(ctype_q), .own_q(own_q)
);

// File: tb/sim_l2ctl_sram_seq.sv
module sim_l2ctl_sram_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] ctype_i = 3'd0;
  logic [7:0] be_i = 8'h00;
  logic       bus_owned_i = 1'b0;
  logic       cads_n, cadv_n, ce_n, coe_n, done_o;
  logic [7:0] bwe_n;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  l2ctl_sram_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctype_i(ctype_i), .be_i(be_i),
    .bus_owned_i(bus_owned_i), .cads_n(cads_n), .cadv_n(cadv_n), .ce_n(ce_n),
    .coe_n(coe_n), .bwe_n(bwe_n), .done_o(done_o)
  );

  // {ctype[2:0], be[7:0], owned}
  localparam int NV = 11;
  localparam logic [11:0] VEC [NV] = '{
    {3'd0, 8'hA5, 1'b1}, {3'd1, 8'h3C, 1'b1}, {3'd1, 8'h00, 1'b1}, {3'd1, 8'hFF, 1'b0},
    {3'd2, 8'h12, 1'b1}, {3'd3, 8'hFF, 1'b1}, {3'd4, 8'h00, 1'b1}, {3'd4, 8'h00, 1'b0},
    {3'd5, 8'hFF, 1'b1}, {3'd6, 8'h0F, 1'b0}, {3'd7, 8'hF0, 1'b1}
  };

  // expected {cads,cadv,ce,coe,bwe[7:0]} for a beat, from the requirements
  function automatic logic [11:0] expect_beat(input logic [2:0] ct, input logic [7:0] be,
                                              input logic own, input int b);
    logic cads, cadv, ce, coe;
    logic [7:0] bwe;
    cads = !(ct == 3'd4 && own && b == 0);                 // R3
    cadv = !(ct <= 3'd3 && b >= 1);                        // R4
    ce   = !(ct <= 3'd4 || b < 2);                         // R5
    coe  = !(ct == 3'd0 || ct == 3'd3 || ct == 3'd4 || (ct >= 3'd5 && b < 2)); // R6 R7
    bwe  = (ct == 3'd1) ? ~be : (ct == 3'd2) ? 8'h00 : 8'hFF;                  // R8
    return {cads, cadv, ce, coe, bwe};
  endfunction

  function automatic logic [12:0] outs();
    return {cads_n, cadv_n, ce_n, coe_n, bwe_n, done_o};
  endfunction

  task automatic check(input string req, input logic [12:0] exp);
    total++;
    if (outs() !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, outs(), exp);
    end
  endtask

  localparam logic [12:0] IDLE = {4'hF, 8'hFF, 1'b0};
  localparam logic [12:0] DONE = {4'hF, 8'hFF, 1'b1};

  task automatic launch(input logic [2:0] ct, input logic [7:0] be, input logic own);
    start_i = 1'b1; ctype_i = ct; be_i = be; bus_owned_i = own;
    @(negedge clk);
    start_i = 1'b0; ctype_i = ~ct; be_i = ~be; bus_owned_i = ~own;
  endtask

  task automatic watch_beats(input logic [2:0] ct, input logic [7:0] be, input logic own,
                             input string req);
    for (int b = 0; b < 4; b++) begin
      check(req, {expect_beat(ct, be, own, b), 1'b0});
      @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset", IDLE);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", IDLE);

    // table walk: R2..R9
    for (int v = 0; v < NV; v++) begin
      launch(VEC[v][11:9], VEC[v][8:1], VEC[v][0]);
      watch_beats(VEC[v][11:9], VEC[v][8:1], VEC[v][0], "R3-8 beat");
      check("R2 done", DONE);
      @(negedge clk);
      check("R1 after done", IDLE);
    end

    // R10: start in mid-window with another code is ignored
    launch(3'd0, 8'h00, 1'b1);
    check("R10 beat0", {expect_beat(3'd0, 8'h00, 1'b1, 0), 1'b0});
    @(negedge clk);
    start_i = 1'b1; ctype_i = 3'd1; be_i = 8'hFF;
    check("R10 beat1", {expect_beat(3'd0, 8'h00, 1'b1, 1), 1'b0});
    @(negedge clk);
    start_i = 1'b0;
    check("R10 beat2", {expect_beat(3'd0, 8'h00, 1'b1, 2), 1'b0});
    @(negedge clk);
    check("R10 beat3", {expect_beat(3'd0, 8'h00, 1'b1, 3), 1'b0});
    @(negedge clk);
    check("R10 done", DONE);
    @(negedge clk);
    check("R10 no restart", IDLE);
    @(negedge clk);
    check("R10 still idle", IDLE);

    // R11: back-to-back start in the done clock
    launch(3'd3, 8'hFF, 1'b1);
    watch_beats(3'd3, 8'hFF, 1'b1, "R11 first");
    check("R11 done", DONE);
    start_i = 1'b1; ctype_i = 3'd1; be_i = 8'h55; bus_owned_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    watch_beats(3'd1, 8'h55, 1'b0, "R11 second");
    check("R11 done2", DONE);
    @(negedge clk);

    // R1: reset mid-window returns strobes high
    launch(3'd2, 8'h00, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid", IDLE);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post reset", IDLE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule